// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order integer pipeline. It decides, for each of the two ALU operands, where the operand value comes from. There are three possible sources: the value read from the register file during decode, the result held in the execute/memory pipeline register (produced by the instruction one ahead), or the result held in the memory/writeback pipeline register (produced by the instruction two ahead).

The block compares the source register numbers of the instruction now in execute with the destination register numbers of the two older in-flight instructions. A comparison only counts if that older instruction actually writes a register and its destination is not register 0. When both older instructions would supply the same operand, the younger one wins, because it holds the most recent value. The block has no state. Both selects follow their inputs within the same cycle and feed the operand multiplexers directly. All pins are plain control signals with no handshake.

Top module: `fwd_unit`

## Requirements
- R1: Operand A select is 2'b10 (take the execute/memory result) whenever `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_a`.
- R2: Operand A select is 2'b01 (take the memory/writeback result) whenever `wb_wen` is 1, `wb_dst` is nonzero, `wb_dst` equals `ex_src_a`, and the R1 condition for operand A is false.
- R3: When the R1 and R2 conditions both match the same operand, the select is 2'b10. The younger producer takes priority.
- R4: Operand B follows the same rules using `ex_src_b`, and is decided independently of operand A. Both operands may receive different codes in the same cycle.
- R5: A destination of register 0 never causes a forward, even when its write-enable is 1.
- R6: When no condition holds, the select is 2'b00 (register-file value). The code 2'b11 is never produced.
- R7: A destination whose write-enable is 0 has no effect on either select, whatever its register number.
- R8: The selects are purely combinational. A change of inputs shows on the outputs within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Source register number of operand A for the instruction in execute |
| ex_src_b | input | 5 | Source register number of operand B for the instruction in execute |
| mem_wen | input | 1 | The instruction in the execute/memory register writes a register |
| mem_dst | input | 5 | Destination register number in the execute/memory register |
| wb_wen | input | 1 | The instruction in the memory/writeback register writes a register |
| wb_dst | input | 5 | Destination register number in the memory/writeback register |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 01 memory/writeback, 10 execute/memory |
| fwd_sel_b | output | 2 | Operand B source, same encoding as operand A |

## Verification
The assertions check, whenever the inputs are known, that each nonzero select code is backed by its producer's write-enable and nonzero matching destination. They also check that the writeback code never appears while the execute/memory producer matches, and that code 11 never appears. These properties only show that a forward, when it is chosen, is justified. They cannot show that a needed forward is missing. The bench's scenarios cover that side: back-to-back writes to one register, register-0 writes with the enable set, disabled producers with matching numbers, operands with different sources in the same cycle, and a random sweep over a small register range so that matches are frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source select encoding shared by the unit and its consumers.
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_WB = 2'b01,
    SEL_EX = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/fwd_hit.sv
// One producer/consumer comparison: does this producer supply this operand?
module fwd_hit #(
  parameter int REG_W = 5
) (
  input  logic             wen,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);

  logic dst_live;

  assign dst_live = wen && (dst != '0);
  assign hit      = dst_live && (dst == src);

endmodule

// File: rtl/fwd_prio.sv
// Resolves the two producer hits for one operand; the younger producer wins.
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     ex_hit,
  input  logic     wb_hit,
  output fwd_sel_e sel
);

  always_comb begin
    if (ex_hit)      sel = SEL_EX;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b
);

  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] op_src [NUM_OPS];
  logic             ex_hit [NUM_OPS];
  logic             wb_hit [NUM_OPS];
  fwd_sel_e         op_sel [NUM_OPS];

  assign op_src[0] = ex_src_a;
  assign op_src[1] = ex_src_b;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    fwd_hit #(.REG_W(REG_W)) u_ex_hit (
      .wen (mem_wen),
      .dst (mem_dst),
      .src (op_src[op]),
      .hit (ex_hit[op])
    );

    fwd_hit #(.REG_W(REG_W)) u_wb_hit (
      .wen (wb_wen),
      .dst (wb_dst),
      .src (op_src[op]),
      .hit (wb_hit[op])
    );

    fwd_prio u_prio (
      .ex_hit (ex_hit[op]),
      .wb_hit (wb_hit[op]),
      .sel    (op_sel[op])
    );
  end

  assign fwd_sel_a = op_sel[0];
  assign fwd_sel_b = op_sel[1];

  // Port-level checks on the selects produced by the submodules.
  always_comb begin
    if (!$isunknown({ex_src_a, ex_src_b, mem_wen, mem_dst, wb_wen, wb_dst})) begin
      p_ex_sel_justified_a_r1: assert (fwd_sel_a != SEL_EX ||
        (mem_wen && mem_dst != '0 && mem_dst == ex_src_a))
        else $error("R1: operand A took EX/MEM without a matching producer");
      p_wb_sel_justified_a_r2: assert (fwd_sel_a != SEL_WB ||
        (wb_wen && wb_dst != '0 && wb_dst == ex_src_a))
        else $error("R2: operand A took MEM/WB without a matching producer");
      p_younger_wins_a_r3: assert (!(fwd_sel_a == SEL_WB &&
        mem_wen && mem_dst != '0 && mem_dst == ex_src_a))
        else $error("R3: operand A chose the older producer");
      p_ex_sel_justified_b_r4: assert (fwd_sel_b != SEL_EX ||
        (mem_wen && mem_dst != '0 && mem_dst == ex_src_b))
        else $error("R4: operand B took EX/MEM without a matching producer");
      p_wb_sel_justified_b_r4: assert (fwd_sel_b != SEL_WB ||
        (wb_wen && wb_dst != '0 && wb_dst == ex_src_b &&
         !(mem_wen && mem_dst != '0 && mem_dst == ex_src_b)))
        else $error("R4: operand B took MEM/WB wrongly");
      p_no_zero_fwd_r5: assert (!((fwd_sel_a == SEL_EX || fwd_sel_b == SEL_EX) && mem_dst == '0) &&
                                !((fwd_sel_a == SEL_WB || fwd_sel_b == SEL_WB) && wb_dst == '0))
        else $error("R5: register 0 forwarded");
      p_no_code3_r6: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
        else $error("R6: reserved select code produced");
      p_idle_is_rf_r7: assert (mem_wen || wb_wen || (fwd_sel_a == SEL_RF && fwd_sel_b == SEL_RF))
        else $error("R7: forward chosen with no writing producer");
    end
  end

endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ex_src_a = '0;
  logic [4:0] ex_src_b = '0;
  logic       mem_wen = 1'b0;
  logic [4:0] mem_dst = '0;
  logic       wb_wen = 1'b0;
  logic [4:0] wb_dst = '0;
  logic [1:0] fwd_sel_a;
  logic [1:0] fwd_sel_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit stim_done = 1'b0;

  logic [1:0] exp_a_q [$];
  logic [1:0] exp_b_q [$];
  string      tag_q   [$];

  always #2 clk = ~clk;  // 250 MHz

  fwd_unit u_fwd_unit (
    .ex_src_a  (ex_src_a),
    .ex_src_b  (ex_src_b),
    .mem_wen   (mem_wen),
    .mem_dst   (mem_dst),
    .wb_wen    (wb_wen),
    .wb_dst    (wb_dst),
    .fwd_sel_a (fwd_sel_a),
    .fwd_sel_b (fwd_sel_b)
  );

  // Expected select written from the requirements.
  function automatic logic [1:0] model_sel(input logic [4:0] src,
                                           input logic mw, input logic [4:0] md,
                                           input logic ww, input logic [4:0] wd);
    if (mw && md != 5'd0 && md == src) return 2'b10;
    if (ww && wd != 5'd0 && wd == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                       input logic mw, input logic [4:0] md,
                       input logic ww, input logic [4:0] wd,
                       input string tag);
    @(negedge clk);
    ex_src_a = sa; ex_src_b = sb;
    mem_wen = mw; mem_dst = md;
    wb_wen = ww; wb_dst = wd;
    exp_a_q.push_back(model_sel(sa, mw, md, ww, wd));
    exp_b_q.push_back(model_sel(sb, mw, md, ww, wd));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare the outputs at the edge after each drive.
  always @(posedge clk) begin
    if (rst_n && exp_a_q.size() > 0) begin
      logic [1:0] ea, eb;
      string t;
      ea = exp_a_q.pop_front();
      eb = exp_b_q.pop_front();
      t  = tag_q.pop_front();
      n_tests++;
      if (fwd_sel_a !== ea) begin
        n_fail++;
        $display("FAIL %s operand A actual=%b expected=%b", t, fwd_sel_a, ea);
      end
      n_tests++;
      if (fwd_sel_b !== eb) begin
        n_fail++;
        $display("FAIL %s operand B actual=%b expected=%b", t, fwd_sel_b, eb);
      end
    end
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R6 reset/idle state: nothing writing, selects are register file
    drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, "R6 idle");
    // R1 EX/MEM forward to A
    drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0, "R1 ex to A");
    // R2 MEM/WB forward to A
    drive(5'd7, 5'd9, 1'b0, 5'd7, 1'b1, 5'd7, "R2 wb to A");
    // R3 both match: younger wins on both operands
    drive(5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1, "R3 double hazard");
    // R4 A from EX/MEM, B from MEM/WB in one cycle
    drive(5'd5, 5'd6, 1'b1, 5'd5, 1'b1, 5'd6, "R4 split sources");
    drive(5'd8, 5'd10, 1'b1, 5'd10, 1'b1, 5'd8, "R4 crossed sources");
    // R5 register 0 with write flag set
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, "R5 zero dst");
    drive(5'd0, 5'd2, 1'b1, 5'd0, 1'b1, 5'd2, "R5 zero ex, wb live");
    // R7 disabled producers with matching numbers
    drive(5'd12, 5'd12, 1'b0, 5'd12, 1'b0, 5'd12, "R7 no write");
    drive(5'd13, 5'd13, 1'b0, 5'd13, 1'b1, 5'd13, "R7 ex disabled falls to wb");
    // R6 no match
    drive(5'd31, 5'd30, 1'b1, 5'd29, 1'b1, 5'd28, "R6 no match");
    // R8 inputs change every cycle, outputs follow at once
    drive(5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 5'd30, "R8 change 1");
    drive(5'd31, 5'd30, 1'b0, 5'd31, 1'b0, 5'd30, "R8 change 2");
    for (int i = 0; i < 300; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)), "R1 R2 R3 R4 R5 sweep");
    end
    stim_done = 1'b1;
    while (exp_a_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule